// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. It samples a serial line at sixteen times the bit rate, rebuilds each character, and places it in a one-character holding buffer with a receive flag. Characters carry eight data bits, or nine in the wide mode. In the wide mode the extra bit tells address bytes apart from data bytes, so several nodes can share one line and each node can ignore traffic meant for another.

A filter enable makes the receiver discard data bytes in the wide mode. When address matching is also enabled, it keeps only address bytes that equal the node's own address or the all-ones broadcast value. In the narrow mode the same enable makes acceptance depend on a valid stop bit. Framing, break and overrun flags stay set until software clears them. A separate enable lets any of them drive the receive interrupt as well.

Top module: `mpu_uart_rx`

## Requirements
- R1: In the narrow mode (nine_bit_mode=0) a frame is one low start bit, eight data bits sent LSB first, then a stop bit. With filter_en=0 each completed frame loads rx_data, sets rx_flag and clears rx_bit9.
- R2: In the wide mode (nine_bit_mode=1) nine bits follow the start bit. The first eight go to rx_data LSB first and the ninth goes to rx_bit9.
- R3: A start bit counts only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit time receives nothing.
- R4: In the narrow mode with filter_en=1, a frame whose stop bit is low leaves rx_flag, rx_data and rx_bit9 unchanged.
- R5: In the wide mode with filter_en=1, a frame whose ninth bit is 0 leaves rx_flag, rx_data and rx_bit9 unchanged. A frame whose ninth bit is 1 is accepted.
- R6: In the wide mode with filter_en=1 and auto_addr_en=1, an address frame is accepted only when its eight data bits equal given_addr or 8'hFF.
- R7: fe is set by any completed frame whose stop bit is low. It stays set until clr_fe is pulsed.
- R8: br is set when a frame's data bits, its ninth bit (wide mode) and its stop bit are all 0. After such a frame the receiver waits for the line to go high before it looks for the next start bit.
- R9: If a frame is accepted while rx_flag is still set, oe is set and the earlier rx_data and rx_bit9 are kept.
- R10: rx_irq equals rx_flag OR (stat_int_en AND (fe OR br OR oe)).
- R11: Reset clears every flag and the buffer. Each of clr_flag, clr_fe, clr_br and clr_oe clears only its own flag. When a new event and a clear of the same flag arrive in the same cycle, the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial input, high when idle |
| nine_bit_mode | input | 1 | 1 selects nine data bits, 0 selects eight |
| filter_en | input | 1 | Multiprocessor filter / stop-bit qualification enable |
| auto_addr_en | input | 1 | Address comparison enable (wide mode, filter on) |
| given_addr | input | 8 | Node address for the comparison |
| stat_int_en | input | 1 | Lets error flags raise rx_irq |
| clr_flag | input | 1 | Clears rx_flag |
| clr_fe | input | 1 | Clears fe |
| clr_br | input | 1 | Clears br |
| clr_oe | input | 1 | Clears oe |
| rx_data | output | 8 | Buffered data byte |
| rx_bit9 | output | 1 | Buffered ninth bit |
| rx_flag | output | 1 | Receive flag |
| fe | output | 1 | Framing error flag |
| br | output | 1 | Break flag |
| oe | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The line passes through two synchronizer flops. The sequencer then samples the stop bit at its midpoint and raises a one-cycle completion pulse, and the flags and buffer update on the next clock. With a tick on every cycle, the results are therefore ready about twelve cycles into the stop bit. The bench holds each bit for sixteen cycles and then idles the line for two more bit times before it samples on a falling clock edge. Every check therefore lands well after the update cycle and before the next start bit. rx_irq is combinational from the flags, so it is checked in the same sample and right after stat_int_en changes.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
    localparam int unsigned RX_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             bit9;
        logic             stop_ok;
        logic             all_zero;
    } rx_frame_t;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
    import mpu_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic      nine,
    output logic      done,
    output rx_frame_t frame
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned IW  = $clog2(RX_DW + 1);
    localparam int unsigned MID = OSR / 2 - 1;

    typedef struct packed {
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  idx;
        logic [RX_DW:0] sh;
        logic           done;
        logic           stop;
    } core_t;

    core_t core_d, core_q;
    logic [IW-1:0] last_idx;

    always_comb begin
        last_idx = nine ? IW'(RX_DW) : IW'(RX_DW - 1);
        core_d      = core_q;
        core_d.done = 1'b0;
        if (tick) begin
            unique case (core_q.st)
                ST_IDLE: if (!rxd) begin
                    core_d.st  = ST_START;
                    core_d.cnt = '0;
                end
                ST_START: begin
                    if (core_q.cnt == CW'(MID)) begin
                        core_d.cnt = '0;
                        if (!rxd) begin
                            core_d.st  = ST_DATA;
                            core_d.idx = '0;
                            core_d.sh  = '0;
                        end else begin
                            core_d.st = ST_IDLE;
                        end
                    end else begin
                        core_d.cnt = core_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (core_q.cnt == CW'(OSR - 1)) begin
                        core_d.cnt = '0;
                        core_d.sh[core_q.idx] = rxd;
                        if (core_q.idx == last_idx) core_d.st  = ST_STOP;
                        else                        core_d.idx = core_q.idx + 1'b1;
                    end else begin
                        core_d.cnt = core_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (core_q.cnt == CW'(OSR - 1)) begin
                        core_d.cnt  = '0;
                        core_d.done = 1'b1;
                        core_d.stop = rxd;
                        core_d.st   = rxd ? ST_IDLE : ST_WAITHI;
                    end else begin
                        core_d.cnt = core_q.cnt + 1'b1;
                    end
                end
                ST_WAITHI: if (rxd) core_d.st = ST_IDLE;
                default: core_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.st   <= ST_IDLE;
            core_q.stop <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign done           = core_q.done;
    assign frame.data     = core_q.sh[RX_DW-1:0];
    assign frame.bit9     = core_q.sh[RX_DW];
    assign frame.stop_ok  = core_q.stop;
    assign frame.all_zero = ~core_q.stop && (core_q.sh == '0);
endmodule

// File: rtl/mpu_rx_status.sv
module mpu_rx_status
    import mpu_rx_pkg::*;
#(
    parameter logic [RX_DW-1:0] BCAST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  rx_frame_t        frame,
    input  logic             nine,
    input  logic             filter_en,
    input  logic             auto_addr_en,
    input  logic [RX_DW-1:0] given_addr,
    input  logic             clr_flag,
    input  logic             clr_fe,
    input  logic             clr_br,
    input  logic             clr_oe,
    output logic [RX_DW-1:0] data,
    output logic             bit9,
    output logic             flag,
    output logic             fe,
    output logic             br,
    output logic             oe
);
    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             bit9;
        logic             flag;
        logic             fe;
        logic             br;
        logic             oe;
    } stat_t;

    stat_t st_d, st_q;
    logic  addr_hit, accept;

    always_comb begin
        addr_hit = (frame.data == given_addr) || (frame.data == BCAST);
        if (!nine) accept = !filter_en || frame.stop_ok;
        else       accept = !filter_en || (frame.bit9 && (!auto_addr_en || addr_hit));

        st_d = st_q;
        if (clr_flag) st_d.flag = 1'b0;
        if (clr_fe)   st_d.fe   = 1'b0;
        if (clr_br)   st_d.br   = 1'b0;
        if (clr_oe)   st_d.oe   = 1'b0;
        if (done) begin
            if (!frame.stop_ok) st_d.fe = 1'b1;
            if (frame.all_zero) st_d.br = 1'b1;
            if (accept) begin
                if (st_q.flag && !clr_flag) begin
                    st_d.oe = 1'b1;
                end else begin
                    st_d.data = frame.data;
                    st_d.bit9 = nine & frame.bit9;
                    st_d.flag = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign bit9 = st_q.bit9;
    assign flag = st_q.flag;
    assign fe   = st_q.fe;
    assign br   = st_q.br;
    assign oe   = st_q.oe;
endmodule

// File: rtl/mpu_uart_rx.sv
module mpu_uart_rx
    import mpu_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic             nine_bit_mode,
    input  logic             filter_en,
    input  logic             auto_addr_en,
    input  logic [RX_DW-1:0] given_addr,
    input  logic             stat_int_en,
    input  logic             clr_flag,
    input  logic             clr_fe,
    input  logic             clr_br,
    input  logic             clr_oe,
    output logic [RX_DW-1:0] rx_data,
    output logic             rx_bit9,
    output logic             rx_flag,
    output logic             fe,
    output logic             br,
    output logic             oe,
    output logic             rx_irq
);
    logic      rxd_s;
    logic      done;
    rx_frame_t frame;

    mpu_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    mpu_rx_frame #(.OSR(OSR)) i_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_s),
        .nine(nine_bit_mode), .done(done), .frame(frame)
    );

    mpu_rx_status i_status (
        .clk(clk), .rst_n(rst_n), .done(done), .frame(frame),
        .nine(nine_bit_mode), .filter_en(filter_en),
        .auto_addr_en(auto_addr_en), .given_addr(given_addr),
        .clr_flag(clr_flag), .clr_fe(clr_fe), .clr_br(clr_br), .clr_oe(clr_oe),
        .data(rx_data), .bit9(rx_bit9), .flag(rx_flag),
        .fe(fe), .br(br), .oe(oe)
    );

    assign rx_irq = rx_flag | (stat_int_en & (fe | br | oe));
endmodule

// File: rtl/mpu_uart_rx_chk.sv
module mpu_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nine_bit_mode,
    input logic       filter_en,
    input logic       auto_addr_en,
    input logic [7:0] given_addr,
    input logic       stat_int_en,
    input logic       clr_flag,
    input logic       clr_fe,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       rx_flag,
    input logic       fe,
    input logic       br,
    input logic       oe,
    input logic       rx_irq
);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && !clr_flag |=> rx_flag);

    assert_keep_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && !clr_flag |=> $stable(rx_data) && $stable(rx_bit9));

    assert_fe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fe && !clr_fe |=> fe);

    assert_break_framing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(br) |-> fe);

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rx_flag));

    assert_filter_addr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) && $past(nine_bit_mode) && $past(filter_en) |-> rx_bit9);

    assert_addr_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) && $past(nine_bit_mode) && $past(filter_en) && $past(auto_addr_en)
        |-> (rx_data == $past(given_addr)) || (rx_data == 8'hFF));

    assert_irq_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |-> rx_irq);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_flag && !stat_int_en |-> !rx_irq);

    assert_irq_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_int_en && (fe || br || oe) |-> rx_irq);
endmodule

bind mpu_uart_rx mpu_uart_rx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .nine_bit_mode(nine_bit_mode), .filter_en(filter_en),
    .auto_addr_en(auto_addr_en), .given_addr(given_addr), .stat_int_en(stat_int_en),
    .clr_flag(clr_flag), .clr_fe(clr_fe), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .fe(fe), .br(br), .oe(oe), .rx_irq(rx_irq)
);

// File: tb/test_mpu_uart_rx.sv
module test_mpu_uart_rx;
    localparam time CLK_PERIOD = 10ns;
    localparam int  OSR        = 16;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic       nine_bit_mode = 1'b0;
    logic       filter_en = 1'b0;
    logic       auto_addr_en = 1'b0;
    logic [7:0] given_addr = 8'h5A;
    logic       stat_int_en = 1'b0;
    logic       clr_flag = 1'b0, clr_fe = 1'b0, clr_br = 1'b0, clr_oe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_flag, fe, br, oe, rx_irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_uart_rx i_mpu_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .nine_bit_mode(nine_bit_mode), .filter_en(filter_en),
        .auto_addr_en(auto_addr_en), .given_addr(given_addr),
        .stat_int_en(stat_int_en), .clr_flag(clr_flag), .clr_fe(clr_fe),
        .clr_br(clr_br), .clr_oe(clr_oe), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_flag(rx_flag), .fe(fe), .br(br), .oe(oe), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (OSR) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] v, input int nb, input logic stopb);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(v[i]);
        drive_bit(stopb);
        rxd = 1'b1;
        repeat (2*OSR) @(negedge clk);
    endtask

    task automatic clear_all();
        clr_flag = 1'b1; clr_fe = 1'b1; clr_br = 1'b1; clr_oe = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0; clr_fe = 1'b0; clr_br = 1'b0; clr_oe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset", {rx_data, rx_bit9, rx_flag, fe, br, oe, rx_irq}, 16'h0);

        // R1: narrow mode, every byte value
        for (int v = 0; v < 256; v++) begin
            clear_all();
            send({1'b0, 8'(v)}, 8, 1'b1);
            chk("R1 data", {rx_bit9, rx_flag, rx_data}, {1'b0, 1'b1, 8'(v)});
            chk("R1 noerr", {fe, br, oe}, 3'b000);
        end

        // R2: wide mode, ninth bit stored
        nine_bit_mode = 1'b1;
        clear_all();
        send(9'h1A5, 9, 1'b1);
        chk("R2 bit9=1", {rx_bit9, rx_flag, rx_data}, {1'b1, 1'b1, 8'hA5});
        clear_all();
        send(9'h03C, 9, 1'b1);
        chk("R2 bit9=0", {rx_bit9, rx_flag, rx_data}, {1'b0, 1'b1, 8'h3C});

        // R5: filter drops data bytes, keeps address bytes
        filter_en = 1'b1;
        clear_all();
        send(9'h011, 9, 1'b1);
        chk("R5 data ignored", {rx_bit9, rx_flag, rx_data}, {1'b0, 1'b0, 8'h3C});
        send(9'h122, 9, 1'b1);
        chk("R5 addr taken", {rx_bit9, rx_flag, rx_data}, {1'b1, 1'b1, 8'h22});

        // R6: address recognition sweep, given 0x5A
        auto_addr_en = 1'b1;
        prev = 8'h22;
        for (int v = 0; v < 256; v++) begin
            logic acc;
            acc = (v == 8'h5A) || (v == 8'hFF);
            clear_all();
            send({1'b1, 8'(v)}, 9, 1'b1);
            if (acc) prev = 8'(v);
            chk("R6 match", {7'd0, rx_flag, rx_data}, {7'd0, acc, prev});
        end
        auto_addr_en = 1'b0;

        // R4 / R7: narrow mode with filter, bad stop
        nine_bit_mode = 1'b0;
        clear_all();
        send(9'h081, 8, 1'b0);
        chk("R4 stop qualify", {rx_flag, rx_data}, {1'b0, prev});
        chk("R7 fe set", {fe, br}, 2'b10);
        repeat (50) @(negedge clk);
        chk("R7 fe sticky", fe, 1'b1);
        clr_fe = 1'b1; @(negedge clk); clr_fe = 1'b0; @(negedge clk);
        chk("R11 clr_fe", {fe, br, oe, rx_flag}, 4'b0000);

        // R8: break, then rearm
        filter_en = 1'b0;
        send(9'h000, 8, 1'b0);
        chk("R8 break", {br, fe, rx_flag, rx_data}, {3'b111, 8'h00});
        // R10: error flags gated by enable
        clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0; @(negedge clk);
        chk("R10 irq masked", rx_irq, 1'b0);
        stat_int_en = 1'b1; @(negedge clk);
        chk("R10 irq errors", rx_irq, 1'b1);
        clr_br = 1'b1; @(negedge clk); clr_br = 1'b0; @(negedge clk);
        chk("R11 clr_br only", {br, fe}, 2'b01);
        clear_all();
        chk("R10 irq idle", rx_irq, 1'b0);
        send(9'h055, 8, 1'b1);
        chk("R8 rearm", {rx_flag, rx_data}, {1'b1, 8'h55});

        // R9: overrun keeps older byte
        send(9'h066, 8, 1'b1);
        chk("R9 overrun", {oe, rx_flag, rx_data}, {2'b11, 8'h55});
        chk("R10 irq", rx_irq, 1'b1);
        clr_oe = 1'b1; @(negedge clk); clr_oe = 1'b0; @(negedge clk);
        chk("R11 clr_oe only", {oe, rx_flag}, 2'b01);

        // R3: short low pulse is no start bit
        clear_all();
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (12*OSR) @(negedge clk);
        chk("R3 glitch", {rx_flag, fe, br, rx_data}, {3'b000, 8'h55});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule